// File: doc/BRIEF.md
# Four-Bit Serial GPIO Exchanger

This block sits on the programmable-logic side of a narrow link that moves a nibble of general-purpose I/O in both directions over one shared serial data line. The host owns three signals: a data line it can drive, a clock it toggles, and a direction line that says who owns the data line. While direction is low the host drives data and shifts a new output nibble in, least-significant bit first, one bit on every transition of its clock, rising or falling.

When the host raises direction, the block does two things in the same fabric cycle. It commits the received nibble to its output pins, and it captures the current state of its input pins. It then takes ownership of the data line and presents the captured nibble most-significant bit first, moving to the next bit on each host clock transition. Lowering direction hands the line back to the host and clears the bit counter for the next write.

All three host signals are asynchronous to the fabric clock. Each passes through a two-flop synchroniser before edge detection, so every host event takes effect three fabric cycles after it reaches the pins. That is well inside the host's budget of about eight of its own cycles for clock-to-data and direction-to-first-bit delay. The tristate buffer itself is left to the pad ring: the block provides a data value and an enable.

Top module: `gpx_exchanger`

## Requirements
- R1: After a synchronous reset, `pin_out` is 0, `host_dat_oe` is 0 and `host_dat_o` is 0.
- R2: `host_dat_oe` is 1 only in the read phase. It rises 3 fabric cycles after `host_dir_i` rises and falls 3 fabric cycles after `host_dir_i` falls. While it is 0, `host_dat_o` is 0.
- R3: In the write phase, each transition of `host_clk_i` (either edge) stores the level of `host_dat_i` as the next received bit. Bit 0 is stored first, then bits 1, 2 and 3.
- R4: A 0-to-1 change of `host_dir_i` copies the received nibble to `pin_out` 3 fabric cycles after the change. `pin_out` changes at no other time except reset.
- R5: The nibble read back is the value of `pin_in` at the fabric clock edge where the direction rise is detected. Changes to `pin_in` after that edge do not alter the readback.
- R6: In the read phase, `host_dat_o` first shows bit 3 of the captured nibble. Each host clock transition moves it to bits 2, 1 and then 0, 3 fabric cycles after the transition.
- R7: Host clock transitions beyond the fourth in a phase are ignored. Extra write bits do not change the received nibble, and during a read `host_dat_o` stays on bit 0.
- R8: Every change of direction resets the bit counter. When the host leaves the write phase, received bits that were not written are 0, so a partial write commits zeros in the bit positions it did not reach.
- R9: Lowering `host_dir_i` does not change `pin_out`, which keeps the committed value through the next write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk_i | input | 1 | Host shift clock, both edges active, asynchronous |
| host_dir_i | input | 1 | Line owner: 0 host drives, 1 block drives; asynchronous |
| host_dat_i | input | 1 | Shared data line as seen at the pad input |
| host_dat_o | output | 1 | Value the block drives on the shared data line |
| host_dat_oe | output | 1 | Output enable for the shared data line pad |
| pin_in | input | PIN_W | Input pins captured for readback |
| pin_out | output | PIN_W | Output pins driven from the committed nibble |

## Verification
Every host event reaches the outputs after exactly three fabric clock edges: two synchroniser flops and then the state register. A behavioural reference in the bench therefore delays the host signals by two samples, applies the event rules, and compares `pin_out`, `host_dat_oe` and `host_dat_o` against the design in the middle of every fabric cycle. Directed host transactions hold each line level for five fabric cycles, longer than the three-cycle latency, before sampling. Each known answer (committed nibble, MSB-first readback, ignored extra edges, partial write) is therefore checked only after the result has settled.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic {
        PH_WRITE = 1'b0,
        PH_READ  = 1'b1
    } gpx_phase_e;

    typedef struct packed {
        logic hclk;
        logic dir;
        logic dat;
    } gpx_line_t;

    localparam int LINE_W = $bits(gpx_line_t);

    typedef struct packed {
        logic clk_tog;
        logic dir_rise;
        logic dir_fall;
        logic dat;
    } gpx_event_t;

    function automatic logic any_dir_change(gpx_event_t e);
        return e.dir_rise | e.dir_fall;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpx_edge.sv
module gpx_edge
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gpx_line_t  line_s,
    output gpx_event_t ev
);
    gpx_line_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= line_s;
    end

    always_comb begin
        ev.clk_tog  = line_s.hclk ^ prev.hclk;
        ev.dir_rise = line_s.dir & ~prev.dir;
        ev.dir_fall = ~line_s.dir & prev.dir;
        ev.dat      = line_s.dat;
    end

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  gpx_event_t       ev,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out,
    output logic             dat_o,
    output logic             dat_oe
);
    localparam int CW = $clog2(WIDTH + 1);

    gpx_phase_e       phase;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] rx;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] snap;
    logic [CW-1:0]    sel;
    logic             rd_bit;
    logic             room;

    assign room = (cnt < CW'(WIDTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WRITE;
            cnt   <= '0;
            rx    <= '0;
            out_q <= '0;
            snap  <= '0;
        end else if (ev.dir_rise) begin
            phase <= PH_READ;
            cnt   <= '0;
            out_q <= rx;
            snap  <= pins_in;
        end else if (ev.dir_fall) begin
            phase <= PH_WRITE;
            cnt   <= '0;
            rx    <= '0;
        end else if (ev.clk_tog && room) begin
            if (phase == PH_WRITE) begin
                for (int i = 0; i < WIDTH; i++) begin
                    if (cnt == CW'(i)) rx[i] <= ev.dat;
                end
            end
            cnt <= cnt + CW'(1);
        end
    end

    // Read pointer walks from the top bit down and parks on bit 0.
    always_comb begin
        if (cnt >= CW'(WIDTH - 1)) sel = '0;
        else                       sel = CW'(WIDTH - 1) - cnt;
        rd_bit = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (sel == CW'(i)) rd_bit = snap[i];
        end
    end

    assign pins_out = out_q;
    assign dat_oe   = (phase == PH_READ);
    assign dat_o    = (phase == PH_READ) ? rd_bit : 1'b0;

    // R4: committed value moves only on a detected direction rise
    a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
        !ev.dir_rise |=> $stable(out_q));

    // R7: counter never runs past the nibble
    a_r7_cnt_cap: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(WIDTH));

    // R8: any direction change clears the counter
    a_r8_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        any_dir_change(ev) |=> (cnt == '0));

    // R6: first bit on the line is the top bit of the capture
    a_r6_msb_first: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe) |-> (dat_o == snap[WIDTH-1]));

endmodule

// File: rtl/gpx_exchanger.sv
module gpx_exchanger
    import gpx_pkg::*;
#(
    parameter int PIN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_clk_i,
    input  logic             host_dir_i,
    input  logic             host_dat_i,
    output logic             host_dat_o,
    output logic             host_dat_oe,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out
);
    gpx_line_t  line_raw;
    gpx_line_t  line_s;
    gpx_event_t ev;

    always_comb begin
        line_raw.hclk = host_clk_i;
        line_raw.dir  = host_dir_i;
        line_raw.dat  = host_dat_i;
    end

    gpx_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_raw),
        .q   (line_s)
    );

    gpx_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_s (line_s),
        .ev     (ev)
    );

    gpx_core #(.WIDTH(PIN_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .pins_in  (pin_in),
        .pins_out (pin_out),
        .dat_o    (host_dat_o),
        .dat_oe   (host_dat_oe)
    );

    // R2: line released the cycle after a direction fall is seen
    a_r2_release: assert property (@(posedge clk) disable iff (rst)
        ev.dir_fall |=> !host_dat_oe);

    // R2: nothing driven while the line is released
    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        !host_dat_oe |-> !host_dat_o);

endmodule

// File: tb/gpx_exchanger_test.sv
module gpx_exchanger_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hclk = 1'b0, hdir = 1'b0, hdat = 1'b0;
    logic       dat_o, dat_oe;
    logic [3:0] pin_in = 4'h0;
    logic [3:0] pin_out;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    gpx_exchanger uut (
        .clk (clk), .rst (rst),
        .host_clk_i (hclk), .host_dir_i (hdir), .host_dat_i (hdat),
        .host_dat_o (dat_o), .host_dat_oe (dat_oe),
        .pin_in (pin_in), .pin_out (pin_out)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: host lines seen two samples late, then rules applied.
    logic [2:0] pipe[$];
    logic [2:0] m_prev;
    bit         m_read;
    int         m_cnt;
    logic [3:0] m_rx, m_out, m_snap;

    always @(posedge clk) begin
        if (rst) begin
            pipe = {3'b000, 3'b000};
            m_prev = 3'b000; m_read = 0; m_cnt = 0;
            m_rx = 0; m_out = 0; m_snap = 0;
        end else begin
            logic [2:0] cur;
            cur = pipe[0];
            if (cur[1] && !m_prev[1]) begin
                m_read = 1; m_cnt = 0; m_out = m_rx; m_snap = pin_in;
            end else if (!cur[1] && m_prev[1]) begin
                m_read = 0; m_cnt = 0; m_rx = 0;
            end else if (cur[2] != m_prev[2] && m_cnt < 4) begin
                if (!m_read) m_rx[m_cnt] = cur[0];
                m_cnt++;
            end
            m_prev = cur;
            void'(pipe.pop_front());
            pipe.push_back({hclk, hdir, hdat});
        end
    end

    function automatic logic model_bit();
        int idx;
        if (!m_read) return 1'b0;
        idx = (m_cnt >= 3) ? 0 : 3 - m_cnt;
        return m_snap[idx];
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 cycle pin_out", {4'h0, pin_out}, {4'h0, m_out});
            check("R2 cycle oe", {7'h0, dat_oe}, {7'h0, m_read});
            check("R6 cycle data", {7'h0, dat_o}, {7'h0, model_bit()});
        end
    end

    task automatic hstep();
        repeat (5) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            hdat = v[i];
            hstep();
            hclk = ~hclk;
            hstep();
        end
    endtask

    task automatic host_read(output logic [3:0] got, input int ntog, input logic [3:0] pin_after);
        hdir = 1'b1;
        hstep();
        pin_in = pin_after;
        got = 4'h0;
        for (int i = 0; i < ntog; i++) begin
            if (i < 4) got[3-i] = dat_o;
            else check("R7 read parks on bit0", {7'h0, dat_o}, {7'h0, got[0]});
            hclk = ~hclk;
            hstep();
        end
        if (ntog > 4) check("R7 read parks on bit0", {7'h0, dat_o}, {7'h0, got[0]});
        hdir = 1'b0;
        hstep();
    endtask

    initial begin
        logic [3:0] got;
        repeat (2) @(negedge clk);
        check("R1 reset pin_out", {4'h0, pin_out}, 8'h00);
        check("R1 reset oe", {7'h0, dat_oe}, 8'h00);
        check("R1 reset data", {7'h0, dat_o}, 8'h00);
        rst = 1'b0;
        hstep();

        // R3 / R4: write 1011, commit on direction rise after exactly 3 cycles
        host_write(8'h0B, 4);
        check("R9 no commit before dir rise", {4'h0, pin_out}, 8'h00);
        pin_in = 4'h6;
        @(negedge clk);
        hdir = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 not yet at 2 cycles", {4'h0, pin_out}, 8'h00);
        check("R2 oe not yet at 2 cycles", {7'h0, dat_oe}, 8'h00);
        @(negedge clk);
        check("R4 commit at 3 cycles", {4'h0, pin_out}, 8'h0B);
        check("R2 oe at 3 cycles", {7'h0, dat_oe}, 8'h01);
        check("R6 first bit is bit3 of 0110", {7'h0, dat_o}, 8'h00);
        hstep();
        hdir = 1'b0;
        hstep();
        check("R9 pin_out kept after dir fall", {4'h0, pin_out}, 8'h0B);
        check("R2 released after dir fall", {7'h0, dat_oe}, 8'h00);

        // R5 / R6: capture 1001, then change pins; read MSB first
        pin_in = 4'h9;
        host_write(8'h05, 4);
        host_read(got, 4, 4'h6);
        check("R5 R6 readback of capture", {4'h0, got}, 8'h09);
        check("R4 second commit", {4'h0, pin_out}, 8'h05);

        pin_in = 4'hC;
        host_write(8'h0E, 4);
        host_read(got, 4, 4'h3);
        check("R6 readback 1100", {4'h0, got}, 8'h0C);

        // R7: six write bits, extras ignored; six read toggles
        pin_in = 4'h1;
        host_write(8'b0011_0110, 6);
        host_read(got, 6, 4'hF);
        check("R7 extra write bits ignored", {4'h0, pin_out}, 8'h06);
        check("R7 readback with extra toggles", {4'h0, got}, 8'h01);

        // R8: partial write of three ones, missing top bit is zero
        pin_in = 4'hA;
        host_write(8'h07, 3);
        host_read(got, 4, 4'h0);
        check("R8 partial write zero-filled", {4'h0, pin_out}, 8'h07);
        check("R8 counter restarts for read", {4'h0, got}, 8'h0A);

        // R8: write with no bits commits zero
        host_read(got, 0, 4'h0);
        check("R8 empty write commits zero", {4'h0, pin_out}, 8'h00);

        hstep();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule